// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Bank

This block is a bank of up to 32 general-purpose pins behind a word-wide memory-mapped register bus. Software picks per pin whether the pad is driven, writes the output data either as a whole word or through dedicated set-mask and clear-mask registers, and reads the pad levels after a two-flop synchronizer and an optional de-bounce filter.

Each pin carries an event detector with a 3-bit mode: high level, low level, falling edge, rising edge or both edges. Events latch into a sticky status register that software clears by writing ones. A single interrupt line is raised while any latched status bit has its enable bit set. Reads are combinational on the address, so read data is valid in the same cycle as the address.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register reads zero: data out (0x24), direction (0x28), interrupt enable (0x50), status (0x64), de-bounce enable (0x70). padOe, padOut and irq are 0.
- R2: padOe equals the direction register (1 = drive, 0 = input) and padOut equals the data-out register. Both read back at their offsets, and padOe changes only after a direction write.
- R3: A write to 0x30 sets exactly the data-out bits written as 1. A write to 0x2C clears exactly those bits. Other bits keep their value, and both offsets read as zero.
- R4: Offset 0x20 returns each pin's filtered input. With de-bounce off, a pad change shows there after the third rising clock edge and not after the second.
- R5: Pin p's mode sits in register 0x54 + 4*(p/8), bits [(p%8)*4+2 : (p%8)*4]. The top bit of each 4-bit slot reads 0.
- R6: Mode 6 latches a rising edge, mode 5 a falling edge and mode 7 either edge. Modes 0, 1 and 4 latch nothing.
- R7: Mode 2 (high) and mode 3 (low) latch the status bit on every cycle the level holds, so a clear does not remove it while the level persists.
- R8: Writing a 1 to a status bit at 0x64 clears it and a 0 leaves it. No status bit falls without such a write, and a same-cycle event beats the clear.
- R9: irq is the OR of (status AND enable at 0x50). Status bits latch whether or not the pin is enabled.
- R10: De-bounce enable (0x70) selects filtered pins. Control (0x74) holds a threshold T in bits [7:0] and a tick select in bit 31: 0 ticks every clock, 1 ticks every DEB_DIV clocks. A filtered pin follows its synchronized input only after T+1 consecutive differing ticks. With 0x80000003 set, pulses shorter than 4 ticks are dropped.
- R11: Offset 0x00 returns the ID_VALUE parameter. Offset 0x10 returns bit 29 = 1 (de-bounce present), bit 31 = 0 (no pull control) and bits [5:0] = NUM_PINS. Pull registers 0x40/0x44 read zero, and writes to any of these four offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| padIn | input | NUM_PINS | Asynchronous pad levels |
| padOut | output | NUM_PINS | Output data to pads |
| padOe | output | NUM_PINS | Pad drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NUM_PINS = 32, so all four mode registers and every nibble slot exist and the top slot of the last register can be tested. It sets DEB_DIV = 2, so the prescaled de-bounce tick differs from the per-clock tick and both can be tested in a short run. With per-clock ticks and threshold 3, pulses of exactly three and four clocks give the filter boundary to the cycle. The prescaled case checks that a short pulse is dropped and a long one passes.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h10;
  localparam logic [7:0] OFS_DIN   = 8'h20;
  localparam logic [7:0] OFS_DOUT  = 8'h24;
  localparam logic [7:0] OFS_DIR   = 8'h28;
  localparam logic [7:0] OFS_CLR   = 8'h2C;
  localparam logic [7:0] OFS_SET   = 8'h30;
  localparam logic [7:0] OFS_PEN   = 8'h40;
  localparam logic [7:0] OFS_PTY   = 8'h44;
  localparam logic [7:0] OFS_IEN   = 8'h50;
  localparam logic [7:0] OFS_MODE0 = 8'h54;
  localparam logic [7:0] OFS_MODE1 = 8'h58;
  localparam logic [7:0] OFS_MODE2 = 8'h5C;
  localparam logic [7:0] OFS_MODE3 = 8'h60;
  localparam logic [7:0] OFS_STA   = 8'h64;
  localparam logic [7:0] OFS_DEBE  = 8'h70;
  localparam logic [7:0] OFS_DEBC  = 8'h74;

  localparam logic [2:0] MODE_HIGH = 3'd2;
  localparam logic [2:0] MODE_LOW  = 3'd3;
  localparam logic [2:0] MODE_FALL = 3'd5;
  localparam logic [2:0] MODE_RISE = 3'd6;
  localparam logic [2:0] MODE_BOTH = 3'd7;

  typedef enum logic [3:0] {
    RD_ZERO, RD_ID, RD_CFG, RD_DIN, RD_DOUT, RD_DIR,
    RD_IEN, RD_MODE, RD_STA, RD_DEBE, RD_DEBC
  } rdsel_t;

  typedef struct packed {
    logic       wrDout;
    logic       wrDir;
    logic       wrClr;
    logic       wrSet;
    logic       wrIen;
    logic [3:0] wrMode;
    logic       wrSta;
    logic       wrDebe;
    logic       wrDebc;
  } strobe_t;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb,
  output rdsel_t            sel,
  output logic [1:0]        modeIdx
);

  logic       inRange;
  logic       wr;
  logic [7:0] ofs;

  assign inRange = ((busAddr >> 8) == '0) && (busAddr[1:0] == 2'b00);
  assign wr      = busEn && busWe && inRange;
  assign ofs     = {busAddr[7:2], 2'b00};

  always_comb begin
    stb     = '0;
    sel     = RD_ZERO;
    modeIdx = 2'd0;
    if (inRange) begin
      case (ofs)
        OFS_ID:    sel = RD_ID;
        OFS_CFG:   sel = RD_CFG;
        OFS_DIN:   sel = RD_DIN;
        OFS_DOUT:  begin sel = RD_DOUT; stb.wrDout = wr; end
        OFS_DIR:   begin sel = RD_DIR;  stb.wrDir  = wr; end
        OFS_CLR:   stb.wrClr = wr;
        OFS_SET:   stb.wrSet = wr;
        OFS_IEN:   begin sel = RD_IEN;  stb.wrIen  = wr; end
        OFS_MODE0: begin sel = RD_MODE; modeIdx = 2'd0; stb.wrMode[0] = wr; end
        OFS_MODE1: begin sel = RD_MODE; modeIdx = 2'd1; stb.wrMode[1] = wr; end
        OFS_MODE2: begin sel = RD_MODE; modeIdx = 2'd2; stb.wrMode[2] = wr; end
        OFS_MODE3: begin sel = RD_MODE; modeIdx = 2'd3; stb.wrMode[3] = wr; end
        OFS_STA:   begin sel = RD_STA;  stb.wrSta  = wr; end
        OFS_DEBE:  begin sel = RD_DEBE; stb.wrDebe = wr; end
        OFS_DEBC:  begin sel = RD_DEBC; stb.wrDebc = wr; end
        default:   sel = RD_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/pinbank_inpath.sv
module pinbank_inpath #(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 8,
  parameter int DEB_DIV  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] debe,
  input  logic [CNT_W-1:0]    debThr,
  input  logic                debPre,
  output logic [NUM_PINS-1:0] filt
);

  localparam int PRE_W = $clog2(DEB_DIV + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DEB_DIV - 1);

  logic [NUM_PINS-1:0] syncA, syncB;
  logic [PRE_W-1:0]    preCnt;
  logic                preTick, tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || preTick) preCnt <= '0;
    else                  preCnt <= preCnt + 1'b1;
  end

  assign preTick = (preCnt == PRE_LAST);
  assign tick    = debPre ? preTick : 1'b1;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    logic [CNT_W-1:0] cnt;
    logic             fq;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
        fq  <= 1'b0;
      end else if (!debe[g]) begin
        cnt <= '0;
        fq  <= syncB[g];
      end else if (syncB[g] == fq) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= debThr) begin
          cnt <= '0;
          fq  <= syncB[g];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filt[g] = fq;
  end

endmodule

// File: rtl/pinbank_events.sv
module pinbank_events
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   filt,
  input  logic [3*NUM_PINS-1:0] modeFlat,
  output logic [NUM_PINS-1:0]   evt
);

  logic [NUM_PINS-1:0] prevVal;

  always_ff @(posedge clk) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= filt;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gDet
    logic hit;
    always_comb begin
      case (modeFlat[3*g +: 3])
        MODE_HIGH: hit = filt[g];
        MODE_LOW:  hit = ~filt[g];
        MODE_FALL: hit = prevVal[g] & ~filt[g];
        MODE_RISE: hit = ~prevVal[g] & filt[g];
        MODE_BOTH: hit = prevVal[g] ^ filt[g];
        default:   hit = 1'b0;
      endcase
    end
    assign evt[g] = hit;
  end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int          NUM_PINS = 32,
  parameter int          CNT_W    = 8,
  parameter logic [31:0] ID_VALUE = 32'h0317_0A01
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  rdsel_t                sel,
  input  logic [1:0]            modeIdx,
  input  logic [31:0]           wdata,
  input  logic [NUM_PINS-1:0]   filt,
  input  logic [NUM_PINS-1:0]   evt,
  output logic [31:0]           rdata,
  output logic [NUM_PINS-1:0]   dout,
  output logic [NUM_PINS-1:0]   dir,
  output logic [NUM_PINS-1:0]   ien,
  output logic [NUM_PINS-1:0]   debe,
  output logic [CNT_W-1:0]      debThr,
  output logic                  debPre,
  output logic [3*NUM_PINS-1:0] modeFlat,
  output logic [NUM_PINS-1:0]   sta,
  output logic                  irq
);

  localparam logic [31:0] CFG_WORD = 32'h2000_0000 | 32'(NUM_PINS);

  logic [NUM_PINS-1:0] wMask;
  logic [31:0]         modeWord [4];

  assign wMask = wdata[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dout   <= '0;
      dir    <= '0;
      ien    <= '0;
      debe   <= '0;
      debThr <= '0;
      debPre <= 1'b0;
      sta    <= '0;
    end else begin
      if (stb.wrDout)     dout <= wMask;
      else if (stb.wrSet) dout <= dout | wMask;
      else if (stb.wrClr) dout <= dout & ~wMask;
      if (stb.wrDir)  dir  <= wMask;
      if (stb.wrIen)  ien  <= wMask;
      if (stb.wrDebe) debe <= wMask;
      if (stb.wrDebc) begin
        debThr <= wdata[CNT_W-1:0];
        debPre <= wdata[31];
      end
      sta <= (sta & ~(stb.wrSta ? wMask : '0)) | evt;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gMode
    localparam int REG = p / 8;
    localparam int SLT = (p % 8) * 4;
    logic [2:0] m;
    always_ff @(posedge clk) begin
      if (!rstN)                m <= '0;
      else if (stb.wrMode[REG]) m <= wdata[SLT +: 3];
    end
    assign modeFlat[3*p +: 3] = m;
  end

  for (genvar k = 0; k < 4; k++) begin : gWord
    for (genvar j = 0; j < 8; j++) begin : gSlot
      localparam int P = 8 * k + j;
      if (P < NUM_PINS) begin : gUsed
        assign modeWord[k][4*j +: 4] = {1'b0, modeFlat[3*P +: 3]};
      end else begin : gFree
        assign modeWord[k][4*j +: 4] = 4'b0;
      end
    end
  end

  always_comb begin
    case (sel)
      RD_ID:   rdata = ID_VALUE;
      RD_CFG:  rdata = CFG_WORD;
      RD_DIN:  rdata = 32'(filt);
      RD_DOUT: rdata = 32'(dout);
      RD_DIR:  rdata = 32'(dir);
      RD_IEN:  rdata = 32'(ien);
      RD_MODE: rdata = modeWord[modeIdx];
      RD_STA:  rdata = 32'(sta);
      RD_DEBE: rdata = 32'(debe);
      RD_DEBC: rdata = {debPre, 31'(debThr)};
      default: rdata = 32'h0;
    endcase
  end

  assign irq = |(sta & ien);

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int          NUM_PINS = 32,
  parameter int          ADDR_W   = 8,
  parameter int          CNT_W    = 8,
  parameter int          DEB_DIV  = 4,
  parameter logic [31:0] ID_VALUE = 32'h0317_0A01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busEn,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irq
);

  strobe_t               stb;
  rdsel_t                sel;
  logic [1:0]            modeIdx;
  logic [NUM_PINS-1:0]   filt, evt, ien, debe, staQ;
  logic [CNT_W-1:0]      debThr;
  logic                  debPre;
  logic [3*NUM_PINS-1:0] modeFlat;

  pinbank_decode #(.ADDR_W(ADDR_W)) uDecode (
    .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .stb(stb), .sel(sel), .modeIdx(modeIdx)
  );

  pinbank_regs #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .ID_VALUE(ID_VALUE)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .sel(sel), .modeIdx(modeIdx),
    .wdata(busWdata), .filt(filt), .evt(evt), .rdata(busRdata),
    .dout(padOut), .dir(padOe), .ien(ien), .debe(debe),
    .debThr(debThr), .debPre(debPre), .modeFlat(modeFlat),
    .sta(staQ), .irq(irq)
  );

  pinbank_inpath #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .DEB_DIV(DEB_DIV)) uInpath (
    .clk(clk), .rstN(rstN), .padIn(padIn), .debe(debe),
    .debThr(debThr), .debPre(debPre), .filt(filt)
  );

  pinbank_events #(.NUM_PINS(NUM_PINS)) uEvents (
    .clk(clk), .rstN(rstN), .filt(filt), .modeFlat(modeFlat), .evt(evt)
  );

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busEn,
  input logic                busWe,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWdata,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] staQ,
  input logic                irq
);

  logic [NUM_PINS-1:0] w;
  logic wrSet, wrClr, wrDir, wrSta, wrIenZero;

  assign w         = busWdata[NUM_PINS-1:0];
  assign wrSet     = busEn && busWe && (busAddr == ADDR_W'(OFS_SET));
  assign wrClr     = busEn && busWe && (busAddr == ADDR_W'(OFS_CLR));
  assign wrDir     = busEn && busWe && (busAddr == ADDR_W'(OFS_DIR));
  assign wrSta     = busEn && busWe && (busAddr == ADDR_W'(OFS_STA));
  assign wrIenZero = busEn && busWe && (busAddr == ADDR_W'(OFS_IEN)) && (w == '0);

  assert_set_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> ((padOut & $past(w)) == $past(w)) &&
              ((padOut & ~$past(w)) == ($past(padOut) & ~$past(w))));

  assert_clr_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((padOut & $past(w)) == '0) &&
              ((padOut & ~$past(w)) == ($past(padOut) & ~$past(w))));

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrDir |=> $stable(padOe));

  assert_sta_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wrSta |=> ((staQ & $past(staQ)) == $past(staQ)));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrIenZero |=> !irq);

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .padOut(padOut), .padOe(padOe), .staQ(staQ), .irq(irq)
);

// File: tb/tb_pinbank_ctrl.sv
`timescale 1ns/1ps
module tb_pinbank_ctrl;
  import pinbank_pkg::*;

  localparam int          N     = 32;
  localparam logic [31:0] TB_ID = 32'h5A10_0C01;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] padIn = '0, padOut, padOe;
  logic        irq;

  int nChecks = 0;
  int nFail   = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  pinbank_ctrl #(.NUM_PINS(N), .ADDR_W(8), .CNT_W(8), .DEB_DIV(2), .ID_VALUE(TB_ID)) dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    busEn = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busEn = 1'b0;
  endtask

  // monitor: compares each read cycle against the oldest expected item
  always @(negedge clk) begin
    #2;
    if (busEn && !busWe) begin
      if (sbq.size() == 0) check(busRdata, 32'hDEAD_BEEF, "unexpected read");
      else begin
        item_t it;
        it = sbq.pop_front();
        check(busRdata, it.exp, it.tag);
      end
    end
  end

  task automatic pulse(input logic [N-1:0] bits, input int len);
    @(negedge clk);
    padIn = padIn | bits;
    repeat (len) @(negedge clk);
    padIn = padIn & ~bits;
  endtask

  initial begin
    #(5ns * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    #2;
    check(32'(padOe), 32'h0, "R1 padOe");
    check(32'(padOut), 32'h0, "R1 padOut");
    check(32'(irq), 32'h0, "R1 irq");
    rd(OFS_DOUT, 32'h0, "R1 dout");
    rd(OFS_DIR,  32'h0, "R1 dir");
    rd(OFS_STA,  32'h0, "R1 status");
    rd(OFS_IEN,  32'h0, "R1 enable");
    rd(OFS_DEBE, 32'h0, "R1 debe");

    // R11 identity, configuration, pull registers
    rd(OFS_ID,  TB_ID, "R11 id");
    rd(OFS_CFG, 32'h2000_0020, "R11 cfg");
    wr(OFS_PEN, 32'hFFFF_FFFF);
    wr(OFS_PTY, 32'hFFFF_FFFF);
    wr(OFS_ID,  32'h1234_5678);
    wr(OFS_CFG, 32'h0000_0000);
    rd(OFS_PEN, 32'h0, "R11 pull enable");
    rd(OFS_PTY, 32'h0, "R11 pull type");
    rd(OFS_ID,  TB_ID, "R11 id after write");
    rd(OFS_CFG, 32'h2000_0020, "R11 cfg after write");

    // R2 direction and data out
    wr(OFS_DIR, 32'h0000_FFFF);
    wr(OFS_DOUT, 32'h1234_5678);
    #2;
    check(32'(padOe), 32'h0000_FFFF, "R2 padOe");
    check(32'(padOut), 32'h1234_5678, "R2 padOut");
    rd(OFS_DIR, 32'h0000_FFFF, "R2 dir read");

    // R3 set and clear masks
    wr(OFS_SET, 32'h8000_0001);
    #2 check(32'(padOut), 32'h9234_5679, "R3 set");
    wr(OFS_CLR, 32'h0000_0078);
    #2 check(32'(padOut), 32'h9234_5601, "R3 clear");
    rd(OFS_SET, 32'h0, "R3 set reads zero");
    rd(OFS_CLR, 32'h0, "R3 clear reads zero");
    rd(OFS_DOUT, 32'h9234_5601, "R3 dout read");

    // R4 input latency: address held, read data is combinational
    @(negedge clk);
    busAddr = OFS_DIN;
    padIn = 32'hA5A5_0F0F;
    @(negedge clk); @(negedge clk);
    #2 check(busRdata, 32'h0, "R4 not after 2 edges");
    @(negedge clk);
    #2 check(busRdata, 32'hA5A5_0F0F, "R4 after 3 edges");
    padIn = '0;
    idle(5);
    rd(OFS_DIN, 32'h0, "R4 back to zero");

    // R5 mode slot layout
    wr(OFS_MODE0, 32'hFFFF_FFFF);
    rd(OFS_MODE0, 32'h7777_7777, "R5 mode0 slots");
    wr(OFS_MODE3, 32'h0000_0F00);
    rd(OFS_MODE3, 32'h0000_0700, "R5 mode3 pin26");
    rd(OFS_STA, 32'h0, "R6 no event on static pins");

    // R6 edge modes
    wr(OFS_MODE0, 32'h0000_4000);   // pin3 mode 4
    wr(OFS_MODE1, 32'h0000_0060);   // pin9 rise
    wr(OFS_MODE2, 32'h0000_0050);   // pin17 fall
    wr(OFS_MODE3, 32'h0000_0700);   // pin26 both
    wr(OFS_STA, 32'hFFFF_FFFF);
    @(negedge clk);
    padIn = 32'h0402_0208;
    idle(6);
    rd(OFS_STA, 32'h0400_0200, "R6 rising");
    wr(OFS_STA, 32'hFFFF_FFFF);
    @(negedge clk);
    padIn = '0;
    idle(6);
    rd(OFS_STA, 32'h0402_0000, "R6 falling");

    // R8 partial clear
    wr(OFS_STA, 32'h0002_0000);
    rd(OFS_STA, 32'h0400_0000, "R8 zeros unaffected");

    // R9 interrupt gating
    wr(OFS_IEN, 32'h0);
    #2 check(32'(irq), 32'h0, "R9 disabled");
    wr(OFS_IEN, 32'h0400_0000);
    #2 check(32'(irq), 32'h1, "R9 enabled pin");
    wr(OFS_IEN, 32'h0000_0200);
    #2 check(32'(irq), 32'h0, "R9 other pin");
    rd(OFS_STA, 32'h0400_0000, "R9 status kept without enable");
    wr(OFS_IEN, 32'h0);
    wr(OFS_STA, 32'hFFFF_FFFF);

    // R7 level modes
    wr(OFS_MODE0, 32'h0000_0002);   // pin0 high
    wr(OFS_MODE1, 32'h0000_0003);   // pin8 low
    wr(OFS_MODE2, 32'h0);
    wr(OFS_MODE3, 32'h0);
    wr(OFS_STA, 32'hFFFF_FFFF);
    rd(OFS_STA, 32'h0000_0100, "R7 low level survives clear");
    @(negedge clk);
    padIn = 32'h0000_0001;
    idle(6);
    rd(OFS_STA, 32'h0000_0101, "R7 high level");
    wr(OFS_STA, 32'h0000_0101);
    rd(OFS_STA, 32'h0000_0101, "R8 set beats clear");
    @(negedge clk);
    padIn = '0;
    idle(6);
    wr(OFS_STA, 32'h0000_0001);
    rd(OFS_STA, 32'h0000_0100, "R7 cleared after level gone");
    wr(OFS_IEN, 32'h0000_0100);
    #2 check(32'(irq), 32'h1, "R9 level irq");
    wr(OFS_IEN, 32'h0);
    wr(OFS_MODE0, 32'h0);
    wr(OFS_MODE1, 32'h0);
    wr(OFS_STA, 32'hFFFF_FFFF);

    // R10 de-bounce, per-clock ticks, threshold 3
    wr(OFS_MODE0, 32'h0000_0066);   // pins 0,1 rise
    wr(OFS_DEBE, 32'h0000_0001);
    wr(OFS_DEBC, 32'h0000_0003);
    rd(OFS_DEBC, 32'h0000_0003, "R10 control read");
    rd(OFS_DEBE, 32'h0000_0001, "R10 enable read");
    wr(OFS_STA, 32'hFFFF_FFFF);
    pulse(32'h3, 3);
    idle(12);
    rd(OFS_STA, 32'h0000_0002, "R10 3-clock pulse dropped");
    wr(OFS_STA, 32'hFFFF_FFFF);
    pulse(32'h3, 4);
    idle(12);
    rd(OFS_STA, 32'h0000_0003, "R10 4-clock pulse passes");
    wr(OFS_STA, 32'hFFFF_FFFF);

    // R10 prescaled ticks
    wr(OFS_DEBC, 32'h8000_0003);
    rd(OFS_DEBC, 32'h8000_0003, "R10 prescaled control read");
    pulse(32'h1, 3);
    idle(20);
    rd(OFS_STA, 32'h0, "R10 prescaled short pulse dropped");
    pulse(32'h1, 20);
    idle(30);
    rd(OFS_STA, 32'h0000_0001, "R10 prescaled long pulse passes");

    idle(3);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule